// File: doc/BRIEF.md
# Trap and Exception-Return Sequencer

This block runs the memory side of two control-transfer instructions in a small CPU. The first is a software trap. The second is the return-from-exception instruction that undoes it. The surrounding core decodes the instruction and supplies the register values the sequence needs: program counter, condition codes, extended control byte and stack pointer. It then raises a start strobe. From that point the sequencer owns a simple word-wide memory bus until the sequence ends.

On a trap, the sequencer saves three registers on a stack that grows downward, with each push decrementing the stack pointer by one word first:

- the return PC, as one word in 16-bit addressing or two words in wide addressing;
- the condition codes;
- the extended control byte, when that byte is enabled.

It then forces the interrupt mask flag on. Last, it fetches the new PC from one of four vector entries, picked by a 2-bit trap number.

The return pops the same words in the opposite order, with each pop incrementing the stack pointer. Every saved flag therefore comes back exactly.

Each sequence takes a fixed number of cycles. That number depends on the addressing mode and on whether the extended byte is enabled. A busy flag covers the sequence. A one-cycle done pulse follows it, and in that cycle the result registers are valid.

Top module: `trap_rte_seq`

## Requirements
- R1: After reset, busy, done and mem_req are 0, and pc_out, ccr_out, exr_out and sp_out are 0.
- R2: Trap write order and addresses:
  - Each trap write goes to the current stack pointer minus 2, and the stack pointer then takes that value.
  - First the low 16 bits of pc_in are written. In wide mode (adv_mode=1) the high 16 bits follow.
  - Next comes ccr_in, zero-extended to 16 bits.
  - Last comes exr_in, zero-extended, and only when ext_en=1.
- R3: Trap vector fetch:
  - In 16-bit mode the new PC is the word read at VEC_BASE + 2*trap_num, with the upper 16 bits cleared.
  - In wide mode the high word is read at VEC_BASE + 4*trap_num and the low word at that address plus 2.
- R4: After a trap, ccr_out equals ccr_in with bit 7 (the interrupt mask) set to 1. All other bits are unchanged, and exr_out equals exr_in.
- R5: Return read order and addresses:
  - Each return read comes from the current stack pointer, which then increases by 2.
  - First the extended byte is read, only when ext_en=1. Then the condition codes (low byte of the word).
  - Then the PC: in wide mode the high word and then the low word; in 16-bit mode one word, with the upper 16 bits cleared.
  - When ext_en=0, exr_out keeps exr_in.
- R6: busy is high for the following number of cycles, starting the cycle after a start is accepted:
  - trap: 7 cycles in 16-bit mode, 8 in wide mode;
  - return: 5 cycles in either mode;
  - each of these is one cycle longer when ext_en=1.
- R7: Before its bus accesses, every sequence holds mem_req low for the cycles that remain of its count.
- R8: sp_out at done is sp_in minus the bytes pushed (trap) or plus the bytes popped (return), 2 bytes per word. An even stack pointer stays even.
- R9: Start strobes and changes on trap_num and sp_in while busy is high have no effect on the bus accesses or results of the running sequence.
- R10: done is high for exactly one cycle, the cycle right after busy falls, and the result outputs hold their final values in that cycle.
- R11: If start_trap and start_rte are high together while idle, the trap sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_trap | input | 1 | Begin a trap sequence (taken while idle) |
| start_rte | input | 1 | Begin a return sequence (taken while idle) |
| trap_num | input | 2 | Vector selector for a trap |
| adv_mode | input | 1 | 1 = wide addressing (two-word PC), 0 = 16-bit |
| ext_en | input | 1 | Stack the extended control byte |
| pc_in | input | 32 | Return PC to save on a trap |
| ccr_in | input | 8 | Condition codes to save on a trap |
| exr_in | input | 8 | Extended control byte to save on a trap |
| sp_in | input | 32 | Stack pointer at start |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle of the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end pulse |
| pc_out | output | 32 | Resulting program counter |
| ccr_out | output | 8 | Resulting condition codes |
| exr_out | output | 8 | Resulting extended control byte |
| sp_out | output | 32 | Resulting stack pointer |

## Verification
The bench builds the block with its default parameters:

- a 16-bit word;
- a 32-bit stack pointer;
- vectors based at byte 0x40;
- cycle totals of 7, 8 and 5.

Addressing mode and the extended-byte enable are ports, so one build covers all four mode combinations, every trap number, and round trips of trap followed by return. The same build also reaches stray starts during a sequence and a simultaneous trap and return start.

// File: rtl/trseq_pkg.sv
package trseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_CCR,
        ST_PUSH_EXR,
        ST_VEC_H,
        ST_VEC_L,
        ST_POP_EXR,
        ST_POP_CCR,
        ST_POP_PCH,
        ST_POP_PCL,
        ST_FIN
    } seq_st_e;

endpackage

// File: rtl/trseq_plan.sv
module trseq_plan #(
    parameter int CNTW        = 4,
    parameter int TRAP_NRM_ST = 7,
    parameter int TRAP_ADV_ST = 8,
    parameter int RTE_ST      = 5
) (
    input  logic            is_trap,
    input  logic            adv,
    output logic [CNTW-1:0] wait_m1
);
    // bus accesses without the optional extended byte
    localparam int TN_ACC = 3;
    localparam int TA_ACC = 5;
    localparam int RN_ACC = 2;
    localparam int RA_ACC = 3;
    localparam logic [CNTW-1:0] TN_W = CNTW'(TRAP_NRM_ST - TN_ACC - 1);
    localparam logic [CNTW-1:0] TA_W = CNTW'(TRAP_ADV_ST - TA_ACC - 1);
    localparam logic [CNTW-1:0] RN_W = CNTW'(RTE_ST - RN_ACC - 1);
    localparam logic [CNTW-1:0] RA_W = CNTW'(RTE_ST - RA_ACC - 1);

    always_comb begin
        if (is_trap) wait_m1 = adv ? TA_W : TN_W;
        else         wait_m1 = adv ? RA_W : RN_W;
    end
endmodule

// File: rtl/trseq_vec.sv
module trseq_vec #(
    parameter int          SPW      = 32,
    parameter int unsigned VEC_BASE = 32'h40
) (
    input  logic [1:0]     num,
    input  logic           adv,
    input  logic           low,
    output logic [SPW-1:0] addr
);
    localparam logic [SPW-1:0] BASE = SPW'(VEC_BASE);

    logic [SPW-1:0] offs;

    always_comb begin
        offs = adv ? SPW'({num, 2'b00}) : SPW'({num, 1'b0});
        addr = BASE + offs + ((low && adv) ? SPW'(2) : '0);
    end
endmodule

// File: rtl/trap_rte_seq.sv
module trap_rte_seq
    import trseq_pkg::*;
#(
    parameter int          DW          = 16,
    parameter int          SPW         = 32,
    parameter int          CW          = 8,
    parameter int          I_BIT       = 7,
    parameter int unsigned VEC_BASE    = 32'h40,
    parameter int          TRAP_NRM_ST = 7,
    parameter int          TRAP_ADV_ST = 8,
    parameter int          RTE_ST      = 5,
    parameter int          CNTW        = 4,
    localparam int         PCW         = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_trap,
    input  logic           start_rte,
    input  logic [1:0]     trap_num,
    input  logic           adv_mode,
    input  logic           ext_en,
    input  logic [PCW-1:0] pc_in,
    input  logic [CW-1:0]  ccr_in,
    input  logic [CW-1:0]  exr_in,
    input  logic [SPW-1:0] sp_in,
    output logic           mem_req,
    output logic           mem_we,
    output logic [SPW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           busy,
    output logic           done,
    output logic [PCW-1:0] pc_out,
    output logic [CW-1:0]  ccr_out,
    output logic [CW-1:0]  exr_out,
    output logic [SPW-1:0] sp_out
);
    localparam logic [SPW-1:0] WSTEP = SPW'(DW / 8);

    typedef struct packed {
        seq_st_e        st;
        logic [CNTW-1:0] cnt;
        logic           is_trap;
        logic           adv;
        logic           xen;
        logic [1:0]     num;
        logic [PCW-1:0] pc;
        logic [CW-1:0]  ccr;
        logic [CW-1:0]  exr;
        logic [SPW-1:0] sp;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [CNTW-1:0] wait_m1;
    logic [SPW-1:0]  vec_addr;

    trseq_plan #(
        .CNTW(CNTW), .TRAP_NRM_ST(TRAP_NRM_ST),
        .TRAP_ADV_ST(TRAP_ADV_ST), .RTE_ST(RTE_ST)
    ) u_plan (
        .is_trap(start_trap),
        .adv    (adv_mode),
        .wait_m1(wait_m1)
    );

    trseq_vec #(.SPW(SPW), .VEC_BASE(VEC_BASE)) u_vec (
        .num (r_q.num),
        .adv (r_q.adv),
        .low (r_q.st == ST_VEC_L),
        .addr(vec_addr)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_trap || start_rte) begin
                    r_d.st      = ST_WAIT;
                    r_d.cnt     = wait_m1;
                    r_d.is_trap = start_trap;
                    r_d.adv     = adv_mode;
                    r_d.xen     = ext_en;
                    r_d.num     = trap_num;
                    r_d.pc      = pc_in;
                    r_d.ccr     = ccr_in;
                    r_d.exr     = exr_in;
                    r_d.sp      = sp_in;
                end
            end
            ST_WAIT: begin
                if (r_q.cnt == '0) begin
                    if (r_q.is_trap) r_d.st = ST_PUSH_PCL;
                    else             r_d.st = r_q.xen ? ST_POP_EXR : ST_POP_CCR;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PUSH_PCL, ST_PUSH_PCH, ST_PUSH_CCR, ST_PUSH_EXR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = r_q.sp - WSTEP;
                r_d.sp   = r_q.sp - WSTEP;
                case (r_q.st)
                    ST_PUSH_PCL: begin
                        mem_wdata = r_q.pc[DW-1:0];
                        r_d.st    = r_q.adv ? ST_PUSH_PCH : ST_PUSH_CCR;
                    end
                    ST_PUSH_PCH: begin
                        mem_wdata = r_q.pc[PCW-1:DW];
                        r_d.st    = ST_PUSH_CCR;
                    end
                    ST_PUSH_CCR: begin
                        mem_wdata         = DW'(r_q.ccr);
                        r_d.ccr[I_BIT]    = 1'b1;
                        if (r_q.xen) r_d.st = ST_PUSH_EXR;
                        else         r_d.st = r_q.adv ? ST_VEC_H : ST_VEC_L;
                    end
                    default: begin
                        mem_wdata = DW'(r_q.exr);
                        r_d.st    = r_q.adv ? ST_VEC_H : ST_VEC_L;
                    end
                endcase
            end
            ST_VEC_H: begin
                mem_req           = 1'b1;
                mem_addr          = vec_addr;
                r_d.pc[PCW-1:DW]  = mem_rdata;
                r_d.st            = ST_VEC_L;
            end
            ST_VEC_L: begin
                mem_req          = 1'b1;
                mem_addr         = vec_addr;
                r_d.pc[DW-1:0]   = mem_rdata;
                if (!r_q.adv) r_d.pc[PCW-1:DW] = '0;
                r_d.st           = ST_FIN;
            end
            ST_POP_EXR, ST_POP_CCR, ST_POP_PCH, ST_POP_PCL: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                r_d.sp   = r_q.sp + WSTEP;
                case (r_q.st)
                    ST_POP_EXR: begin
                        r_d.exr = mem_rdata[CW-1:0];
                        r_d.st  = ST_POP_CCR;
                    end
                    ST_POP_CCR: begin
                        r_d.ccr = mem_rdata[CW-1:0];
                        r_d.st  = r_q.adv ? ST_POP_PCH : ST_POP_PCL;
                    end
                    ST_POP_PCH: begin
                        r_d.pc[PCW-1:DW] = mem_rdata;
                        r_d.st           = ST_POP_PCL;
                    end
                    default: begin
                        r_d.pc[DW-1:0] = mem_rdata;
                        if (!r_q.adv) r_d.pc[PCW-1:DW] = '0;
                        r_d.st         = ST_FIN;
                    end
                endcase
            end
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE) && (r_q.st != ST_FIN);
    assign done    = (r_q.st == ST_FIN);
    assign pc_out  = r_q.pc;
    assign ccr_out = r_q.ccr;
    assign exr_out = r_q.exr;
    assign sp_out  = r_q.sp;
endmodule

// File: rtl/trseq_chk.sv
module trseq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_trap,
    input logic start_rte,
    input logic busy,
    input logic done,
    input logic mem_req,
    input logic sp_lsb,
    input logic imask
);
    logic trap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                          trap_q <= 1'b0;
        else if ((start_trap || start_rte) && !busy && !done) trap_q <= start_trap;
    end

    // R7
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4
    imask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap_q) |-> imask);

    // R8
    sp_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (sp_lsb == $past(sp_lsb)));
endmodule

bind trap_rte_seq trseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_trap(start_trap),
    .start_rte (start_rte),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .sp_lsb    (sp_out[0]),
    .imask     (ccr_out[I_BIT])
);

// File: tb/tb_trap_rte_seq.sv
module tb_trap_rte_seq;
    localparam int CLK_PERIOD = 10;
    localparam int VBASE = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_trap = 1'b0, start_rte = 1'b0;
    logic [1:0]  trap_num = '0;
    logic        adv_mode = 1'b0, ext_en = 1'b0;
    logic [31:0] pc_in = '0, sp_in = '0;
    logic [7:0]  ccr_in = '0, exr_in = '0;
    logic        mem_req, mem_we, busy, done;
    logic [31:0] mem_addr, pc_out, sp_out;
    logic [15:0] mem_wdata, mem_rdata;
    logic [7:0]  ccr_out, exr_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] mem [0:255];
    logic [15:0] refmem [0:255];

    typedef struct packed {
        logic        req;
        logic        we;
        logic [31:0] addr;
        logic [15:0] wd;
    } cyc_t;
    cyc_t q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_rte_seq dut (
        .clk(clk), .rst_n(rst_n), .start_trap(start_trap), .start_rte(start_rte),
        .trap_num(trap_num), .adv_mode(adv_mode), .ext_en(ext_en),
        .pc_in(pc_in), .ccr_in(ccr_in), .exr_in(exr_in), .sp_in(sp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .pc_out(pc_out), .ccr_out(ccr_out), .exr_out(exr_out), .sp_out(sp_out)
    );

    assign mem_rdata = mem[mem_addr[8:1]];

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[8:1]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push_idle(input int n);
        for (int i = 0; i < n; i++) q.push_back('{1'b0, 1'b0, 32'h0, 16'h0});
    endtask

    task automatic push_wr(input logic [31:0] a, input logic [15:0] d);
        q.push_back('{1'b1, 1'b1, a, d});
        refmem[a[8:1]] = d;
    endtask

    task automatic push_rd(input logic [31:0] a);
        q.push_back('{1'b1, 1'b0, a, 16'h0});
    endtask

    task automatic run_seq(input bit trap, input bit both, input bit mid,
                           input logic [31:0] epc, input logic [7:0] eccr,
                           input logic [7:0] eexr, input logic [31:0] esp);
        @(negedge clk);
        start_trap = trap;
        start_rte  = !trap || both;
        @(negedge clk);
        start_trap = 1'b0;
        start_rte  = 1'b0;
        foreach (q[i]) begin
            if (i > 0) @(negedge clk);
            start_trap = 1'b0;
            start_rte  = 1'b0;
            chk("R6 busy during sequence", {31'h0, busy}, 32'h1);
            chk("R10 done low while busy", {31'h0, done}, 32'h0);
            chk("R7 R2 R5 request", {31'h0, mem_req}, {31'h0, q[i].req});
            if (q[i].req) begin
                chk("R2 R5 direction", {31'h0, mem_we}, {31'h0, q[i].we});
                chk("R2 R3 R5 address", mem_addr, q[i].addr);
                if (q[i].we) chk("R2 write data", {16'h0, mem_wdata}, {16'h0, q[i].wd});
            end
            if (mid && i == 1) begin
                start_trap = 1'b1;
                start_rte  = 1'b1;
                trap_num   = ~trap_num;
                sp_in      = sp_in + 32'h20;
            end
        end
        @(negedge clk);
        start_trap = 1'b0;
        start_rte  = 1'b0;
        chk("R6 busy ends", {31'h0, busy}, 32'h0);
        chk("R10 done pulse", {31'h0, done}, 32'h1);
        chk("R3 R5 pc_out", pc_out, epc);
        chk("R4 R5 ccr_out", {24'h0, ccr_out}, {24'h0, eccr});
        chk("R4 R5 exr_out", {24'h0, exr_out}, {24'h0, eexr});
        chk("R8 sp_out", sp_out, esp);
        @(negedge clk);
        chk("R10 done single", {31'h0, done}, 32'h0);
        chk("R9 idle after", {31'h0, busy}, 32'h0);
    endtask

    task automatic do_trap(input logic [1:0] n, input bit adv, input bit xen,
                           input logic [31:0] pc, input logic [7:0] ccr,
                           input logic [7:0] exr, input logic [31:0] sp,
                           input bit both, input bit mid, output logic [31:0] sp_end);
        logic [31:0] s, va, epc;
        int acc;
        trap_num = n; adv_mode = adv; ext_en = xen;
        pc_in = pc; ccr_in = ccr; exr_in = exr; sp_in = sp;
        acc = (adv ? 5 : 3) + (xen ? 1 : 0);
        q.delete();
        push_idle((adv ? 8 : 7) + (xen ? 1 : 0) - acc);
        s = sp - 2; push_wr(s, pc[15:0]);
        if (adv) begin s = s - 2; push_wr(s, pc[31:16]); end
        s = s - 2; push_wr(s, {8'h00, ccr});
        if (xen) begin s = s - 2; push_wr(s, {8'h00, exr}); end
        if (adv) begin
            va = VBASE + 4 * n;
            push_rd(va); push_rd(va + 2);
            epc = {refmem[va[8:1]], refmem[va[8:1] + 8'd1]};
        end else begin
            va = VBASE + 2 * n;
            push_rd(va);
            epc = {16'h0, refmem[va[8:1]]};
        end
        run_seq(1'b1, both, mid, epc, ccr | 8'h80, exr, s);
        sp_end = s;
    endtask

    task automatic do_rte(input bit adv, input bit xen, input logic [31:0] sp,
                          input logic [31:0] epc, input logic [7:0] eccr,
                          input logic [7:0] eexr);
        logic [31:0] s;
        adv_mode = adv; ext_en = xen; sp_in = sp;
        pc_in = 32'hDEAD_BEEF; ccr_in = 8'h3C; exr_in = 8'h5A;
        q.delete();
        push_idle(5 - (adv ? 3 : 2));
        s = sp;
        if (xen) begin push_rd(s); s = s + 2; end
        push_rd(s); s = s + 2;
        if (adv) begin push_rd(s); s = s + 2; end
        push_rd(s); s = s + 2;
        run_seq(1'b0, 1'b0, 1'b0, epc, eccr, xen ? eexr : 8'h5A, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired R6");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] sp_t;
        for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; refmem[i] = 16'h0; end
        for (int k = 0; k < 8; k++) begin
            mem[(VBASE >> 1) + k]    = 16'h1000 + 16'(k * 16'h0111);
            refmem[(VBASE >> 1) + k] = 16'h1000 + 16'(k * 16'h0111);
        end
        repeat (3) @(negedge clk);
        chk("R1 busy reset", {31'h0, busy}, 32'h0);
        chk("R1 done reset", {31'h0, done}, 32'h0);
        chk("R1 req reset", {31'h0, mem_req}, 32'h0);
        chk("R1 pc reset", pc_out, 32'h0);
        chk("R1 sp reset", sp_out, 32'h0);
        chk("R1 ccr exr reset", {16'h0, ccr_out, exr_out}, 32'h0);
        rst_n = 1'b1;

        for (int n = 0; n < 4; n++) begin
            do_trap(2'(n), 1'b0, 1'b0, 32'h1230 + 32'(n * 4), 8'h15 + 8'(n), 8'h03,
                    32'h1F0, 1'b0, 1'b0, sp_t);
            do_rte(1'b0, 1'b0, sp_t, 32'h1230 + 32'(n * 4), 8'h15 + 8'(n), 8'h00);
        end
        do_trap(2'd2, 1'b0, 1'b1, 32'h0000_4A26, 8'h2B, 8'h87, 32'h1F0, 1'b0, 1'b0, sp_t);
        do_rte(1'b0, 1'b1, sp_t, 32'h0000_4A26, 8'h2B, 8'h87);
        do_trap(2'd1, 1'b1, 1'b0, 32'h00AB_CDE2, 8'h0F, 8'h11, 32'h1F0, 1'b0, 1'b0, sp_t);
        do_rte(1'b1, 1'b0, sp_t, 32'h00AB_CDE2, 8'h0F, 8'h00);
        do_trap(2'd3, 1'b1, 1'b1, 32'h0012_3456, 8'h80, 8'h42, 32'h1E0, 1'b0, 1'b0, sp_t);
        do_rte(1'b1, 1'b1, sp_t, 32'h0012_3456, 8'h80, 8'h42);
        // R9: stray starts and input changes while busy
        do_trap(2'd1, 1'b1, 1'b1, 32'h0077_0010, 8'h41, 8'h09, 32'h1F0, 1'b0, 1'b1, sp_t);
        do_rte(1'b1, 1'b1, sp_t, 32'h0077_0010, 8'h41, 8'h09);
        // R11: both starts together select the trap
        do_trap(2'd0, 1'b0, 1'b0, 32'h0000_0ACE, 8'h02, 8'h00, 32'h1F0, 1'b1, 1'b0, sp_t);
        do_rte(1'b0, 1'b0, sp_t, 32'h0000_0ACE, 8'h02, 8'h00);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule